// File: doc/BRIEF.md
# Two-Line Pixel Composer with Paired Parity Banks

The block keeps two scanline stores. While one store is streamed to the display one pixel per active clock, the other is composed from incoming pixel pairs. A select bit chosen by the line sequencer decides which store plays which role. The sequencer flips it during each horizontal blank, so the roles swap at every new scanline.

Each store is built from two banks of half the line length: one holds even pixel positions and the other holds odd positions. A composition step carries two pixels, A and B, which land at consecutive positions starting at the write pointer. Because of the parity split, one even-bank write and one odd-bank write are always enough, whether the pointer is even or odd. Each pixel carries an opaque flag, and a transparent pixel leaves the stored value untouched. Later opaque sprites therefore paint over earlier ones. A step taken with the load input low does not write: it sets the write pointer to a sprite X position instead.

Top module: `scanline_dbuf`

## Requirements
- R1: After reset, `vid_vld` is 0 and the write pointer is 0, so the first data step without a preceding load writes positions 0 and 1.
- R2: With `bank_sel` = 0, store A is streamed out and store B is composed. With `bank_sel` = 1, store B is streamed out and store A is composed. The streamed store is never written.
- R3: A data step (`step`=1, `load_n`=1) puts `pix_a` at pointer position p and `pix_b` at position p+1 (mod line length). This works for both even and odd p, and each store bank takes at most one write per cycle.
- R4: A pixel whose opaque flag is 0 is not written, and the old value at its position stays intact.
- R5: A load step (`step`=1, `load_n`=0) writes nothing and sets the write pointer to `x_pos` modulo the line length (384 by default). For example, `x_pos`=401 gives 17.
- R6: Each data step advances the write pointer by 2 modulo the line length. A pair started at position 383 puts `pix_b` at position 0.
- R7: While `hblank` is 1, steps and loads have no effect, `vid_vld` is 0 one cycle later, and the read position returns to pixel 0.
- R8: On the k-th active (`hblank`=0) cycle of a line, counted from 0, the stored pixel k of the streamed store appears on `vid_pix` one cycle later, with `vid_vld`=1.
- R9: When opaque pixels from sprites written later overlap earlier ones, the later pixels win, position by position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | 0: A streamed / B composed; 1: the reverse |
| hblank | input | 1 | Horizontal blank; freezes composition, restarts readout |
| step | input | 1 | Composition step strobe |
| load_n | input | 1 | Low during a step: load X position instead of writing |
| x_pos | input | XW (9) | Sprite X start position |
| pix_a | input | CW (12) | Colour of the first pixel of the pair |
| opq_a | input | 1 | Opaque flag of `pix_a` |
| pix_b | input | CW (12) | Colour of the second pixel of the pair |
| opq_b | input | 1 | Opaque flag of `pix_b` |
| vid_pix | output | CW (12) | Streamed pixel colour |
| vid_vld | output | 1 | `vid_pix` carries an active pixel |

## Verification
The assertions check on every cycle that:
- no bank of the streamed store and no bank at all during blank is written;
- a pair of transparent pixels causes no write and each bank takes at most one write;
- the write pointer lands on the loaded X modulo the line, or advances by two with wrap;
- `vid_vld` follows the blank input with one cycle of delay.

Only the bench's line-by-line scenarios can show that data written in one line comes back at the right pixel index in the next line. The same holds for overlapping sprites resolving in favour of the later opaque pixels, for odd starts and wrap at the line end placing pixels correctly, and for strobes during blank leaving the store untouched.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  // Position of pixel v folded into a line of the given length.
  function automatic int wrap_pos(input int v, input int line);
    return v % line;
  endfunction

  // Even-bank slot receiving the even pixel of a pair starting at p.
  function automatic int even_slot(input int p, input int line);
    return ((p + 1) >> 1) % (line / 2);
  endfunction

  // Odd-bank slot receiving the odd pixel of a pair starting at p.
  function automatic int odd_slot(input int p);
    return p >> 1;
  endfunction
endpackage

// File: rtl/dbuf_bank.sv
module dbuf_bank #(
  parameter int DEPTH = 192,
  parameter int CW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbuf_wr_ctl.sv
module dbuf_wr_ctl #(
  parameter int LINE = 384,
  parameter int CW   = 12,
  parameter int XW   = 9,
  localparam int PW  = $clog2(LINE),
  localparam int IW  = $clog2(LINE / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hblank,
  input  logic          step,
  input  logic          load_n,
  input  logic [XW-1:0] x_pos,
  input  logic [CW-1:0] pix_a,
  input  logic          opq_a,
  input  logic [CW-1:0] pix_b,
  input  logic          opq_b,
  output logic [PW-1:0] wr_ptr,
  output logic          ev_we,
  output logic [IW-1:0] ev_idx,
  output logic [CW-1:0] ev_dat,
  output logic          od_we,
  output logic [IW-1:0] od_idx,
  output logic [CW-1:0] od_dat
);
  import dbuf_pkg::*;

  logic ld_evt, wr_evt, odd_start;

  assign ld_evt    = step && !hblank && !load_n;
  assign wr_evt    = step && !hblank && load_n;
  assign odd_start = wr_ptr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_ptr <= '0;
    else if (ld_evt) wr_ptr <= PW'(wrap_pos(int'(x_pos), LINE));
    else if (wr_evt) wr_ptr <= PW'(wrap_pos(int'(wr_ptr) + 2, LINE));
  end

  // Even start: A -> even, B -> odd. Odd start: A -> odd, B -> next even.
  always_comb begin
    ev_idx = IW'(even_slot(int'(wr_ptr), LINE));
    od_idx = IW'(odd_slot(int'(wr_ptr)));
    if (odd_start) begin
      ev_dat = pix_b;  ev_we = wr_evt && opq_b;
      od_dat = pix_a;  od_we = wr_evt && opq_a;
    end else begin
      ev_dat = pix_a;  ev_we = wr_evt && opq_a;
      od_dat = pix_b;  od_we = wr_evt && opq_b;
    end
  end
endmodule

// File: rtl/dbuf_rd_ctl.sv
module dbuf_rd_ctl #(
  parameter int LINE = 384,
  localparam int PW  = $clog2(LINE),
  localparam int IW  = $clog2(LINE / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hblank,
  input  logic          bank_sel,
  output logic [PW-1:0] rd_ptr,
  output logic [IW-1:0] rd_idx,
  output logic          par_q,
  output logic          pair_q,
  output logic          vld_q
);
  import dbuf_pkg::*;

  assign rd_idx = IW'(rd_ptr >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      par_q  <= 1'b0;
      pair_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= !hblank;
      if (hblank) begin
        rd_ptr <= '0;
      end else begin
        rd_ptr <= PW'(wrap_pos(int'(rd_ptr) + 1, LINE));
        par_q  <= rd_ptr[0];
        pair_q <= bank_sel;
      end
    end
  end
endmodule

// File: rtl/scanline_dbuf.sv
module scanline_dbuf #(
  parameter int LINE = 384,
  parameter int CW   = 12,
  parameter int XW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_sel,
  input  logic          hblank,
  input  logic          step,
  input  logic          load_n,
  input  logic [XW-1:0] x_pos,
  input  logic [CW-1:0] pix_a,
  input  logic          opq_a,
  input  logic [CW-1:0] pix_b,
  input  logic          opq_b,
  output logic [CW-1:0] vid_pix,
  output logic          vid_vld
);
  localparam int PW    = $clog2(LINE);
  localparam int DEPTH = LINE / 2;
  localparam int IW    = $clog2(DEPTH);
  localparam int NBANK = 4;

  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             ev_we, od_we, par_q, pair_q, wr_pair;
  logic [IW-1:0]    ev_idx, od_idx, rd_idx;
  logic [CW-1:0]    ev_dat, od_dat;
  logic [NBANK-1:0] we_vec;
  logic [CW-1:0]    rdata [NBANK];

  assign wr_pair = ~bank_sel;  // 0 = store A, 1 = store B

  dbuf_wr_ctl #(.LINE(LINE), .CW(CW), .XW(XW)) u_wr (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .step(step), .load_n(load_n),
    .x_pos(x_pos), .pix_a(pix_a), .opq_a(opq_a), .pix_b(pix_b), .opq_b(opq_b),
    .wr_ptr(wr_ptr), .ev_we(ev_we), .ev_idx(ev_idx), .ev_dat(ev_dat),
    .od_we(od_we), .od_idx(od_idx), .od_dat(od_dat)
  );

  dbuf_rd_ctl #(.LINE(LINE)) u_rd (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .bank_sel(bank_sel),
    .rd_ptr(rd_ptr), .rd_idx(rd_idx), .par_q(par_q), .pair_q(pair_q),
    .vld_q(vid_vld)
  );

  // Bank k: store k/2 (0 = A, 1 = B), parity k%2 (0 = even, 1 = odd).
  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    localparam bit PAIR = 1'(k / 2);
    localparam bit PAR  = 1'(k % 2);
    assign we_vec[k] = (wr_pair == PAIR) && (PAR ? od_we : ev_we);
    dbuf_bank #(.DEPTH(DEPTH), .CW(CW)) u_bank (
      .clk(clk), .we(we_vec[k]),
      .waddr(PAR ? od_idx : ev_idx), .wdata(PAR ? od_dat : ev_dat),
      .raddr(rd_idx), .rdata(rdata[k])
    );
  end

  assign vid_pix = rdata[{pair_q, par_q}];
endmodule

// File: rtl/scanline_dbuf_chk.sv
module scanline_dbuf_chk #(
  parameter int LINE = 384,
  parameter int XW   = 9,
  localparam int PW  = $clog2(LINE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bank_sel,
  input logic          hblank,
  input logic          step,
  input logic          load_n,
  input logic [XW-1:0] x_pos,
  input logic          opq_a,
  input logic          opq_b,
  input logic          vid_vld,
  input logic [3:0]    we_vec,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr
);
  import dbuf_pkg::*;

  a_r2_read_store_a_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_sel |-> we_vec[1:0] == 2'b00);
  a_r2_read_store_b_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel |-> we_vec[3:2] == 2'b00);
  a_r3_one_write_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(we_vec) <= 2);
  a_r4_transparent_pair_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!opq_a && !opq_b) |-> we_vec == 4'b0000);
  a_r5_load_sets_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_n && !hblank) |=> wr_ptr == PW'(wrap_pos(int'($past(x_pos)), LINE)));
  a_r5_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_n) |-> we_vec == 4'b0000);
  a_r6_pointer_steps_two: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load_n && !hblank) |=> wr_ptr == PW'(wrap_pos(int'($past(wr_ptr)) + 2, LINE)));
  a_r6_pointers_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < LINE) && (int'(rd_ptr) < LINE));
  a_r7_blank_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |-> we_vec == 4'b0000);
  a_r7_blank_holds_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |=> $stable(wr_ptr));
  a_r7_blank_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |=> !vid_vld);
  a_r8_active_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !hblank |=> vid_vld);
endmodule

bind scanline_dbuf scanline_dbuf_chk #(.LINE(LINE), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .hblank(hblank), .step(step),
  .load_n(load_n), .x_pos(x_pos), .opq_a(opq_a), .opq_b(opq_b),
  .vid_vld(vid_vld), .we_vec(we_vec), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/scanline_dbuf_test.sv
`timescale 1ns/1ps
module scanline_dbuf_test;
  localparam int LINE = 384;
  localparam int CW   = 12;
  localparam int XW   = 9;
  localparam int MAXOP = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_sel = 1'b1, hblank = 1'b1, step = 1'b0, load_n = 1'b1;
  logic [XW-1:0] x_pos = '0;
  logic [CW-1:0] pix_a = '0, pix_b = '0;
  logic opq_a = 1'b0, opq_b = 1'b0;
  logic [CW-1:0] vid_pix;
  logic vid_vld;

  scanline_dbuf #(.LINE(LINE), .CW(CW), .XW(XW)) uut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .hblank(hblank), .step(step),
    .load_n(load_n), .x_pos(x_pos), .pix_a(pix_a), .opq_a(opq_a),
    .pix_b(pix_b), .opq_b(opq_b), .vid_pix(vid_pix), .vid_vld(vid_vld)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [CW-1:0] ref_mem [2][LINE];
  int wp_model = 0;

  // Per-line composition script
  bit            op_ld [MAXOP];
  logic [XW-1:0] op_x  [MAXOP];
  logic [CW-1:0] op_pa [MAXOP], op_pb [MAXOP];
  bit            op_oa [MAXOP], op_ob [MAXOP];
  int            op_n = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic add_load(input int x);
    op_ld[op_n] = 1'b1; op_x[op_n] = XW'(x);
    op_pa[op_n] = '0; op_pb[op_n] = '0; op_oa[op_n] = 1'b0; op_ob[op_n] = 1'b0;
    op_n++;
  endtask

  task automatic add_pair(input int ca, input bit oa, input int cb, input bit ob);
    op_ld[op_n] = 1'b0; op_x[op_n] = '0;
    op_pa[op_n] = CW'(ca); op_pb[op_n] = CW'(cb); op_oa[op_n] = oa; op_ob[op_n] = ob;
    op_n++;
  endtask

  // A sprite of n pairs with a seed-driven transparency pattern (R4, R9)
  task automatic add_sprite(input int x, input int pairs, input int seed);
    add_load(x);
    for (int i = 0; i < pairs; i++)
      add_pair((seed << 6) + 2 * i, ((i + seed) % 3) != 0,
               (seed << 6) + 2 * i + 1, ((i * 7 + seed) % 4) != 1);
  endtask

  // Active line: composes from the script, streams and checks the other store
  task automatic run_line(input bit chk);
    int wpair, rpair;
    wpair = bank_sel ? 0 : 1;
    rpair = bank_sel ? 1 : 0;
    for (int k = 0; k < LINE; k++) begin
      hblank = 1'b0;
      step   = (k < op_n);
      load_n = (k < op_n) ? !op_ld[k] : 1'b1;
      x_pos  = (k < op_n) ? op_x[k]  : '0;
      pix_a  = (k < op_n) ? op_pa[k] : '0;
      pix_b  = (k < op_n) ? op_pb[k] : '0;
      opq_a  = (k < op_n) ? op_oa[k] : 1'b0;
      opq_b  = (k < op_n) ? op_ob[k] : 1'b0;
      @(posedge clk);
      if (k < op_n) begin
        if (op_ld[k]) wp_model = int'(op_x[k]) % LINE;
        else begin
          if (op_oa[k]) ref_mem[wpair][wp_model] = op_pa[k];
          if (op_ob[k]) ref_mem[wpair][(wp_model + 1) % LINE] = op_pb[k];
          wp_model = (wp_model + 2) % LINE;
        end
      end
      @(negedge clk);
      if (chk)  // R8 stream order, R2 store choice, R3/R4/R5/R6/R9 contents
        check(vid_vld === 1'b1 && vid_pix === ref_mem[rpair][k], "R8/R2 pixel",
              int'({vid_vld, vid_pix}), int'({1'b1, ref_mem[rpair][k]}));
    end
    op_n = 0;
  endtask

  // Blank with junk strobes that must have no effect (R7), then new select
  task automatic run_blank(input bit next_sel);
    for (int c = 0; c < 4; c++) begin
      hblank = 1'b1; step = 1'b1; load_n = c[0];
      x_pos = XW'(77 + c); pix_a = 12'hEEE; pix_b = 12'hDDD; opq_a = 1'b1; opq_b = 1'b1;
      if (c == 1) bank_sel = next_sel;
      @(posedge clk);
      @(negedge clk);
      check(vid_vld === 1'b0, "R7 blank valid", int'(vid_vld), 0);
    end
    step = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < LINE; i++) ref_mem[p][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(vid_vld === 1'b0, "R1 reset valid", int'(vid_vld), 0);

    // Line 0: fill store A without a load, relying on the R1 reset pointer
    bank_sel = 1'b1;
    for (int i = 0; i < LINE / 2; i++) add_pair(12'h400 + 2 * i, 1'b1, 12'h401 + 2 * i, 1'b1);
    run_line(1'b0);
    run_blank(1'b0);

    // Line 1: fill store B, check store A background (R1, R2, R3)
    add_load(0);
    for (int i = 0; i < LINE / 2; i++) add_pair(12'h600 + 2 * i, 1'b1, 12'h601 + 2 * i, 1'b1);
    run_line(1'b1);
    run_blank(1'b1);

    // Line 2: sprites into A: even, odd overlap, wrap at 380, X>=384 (R5, R6, R9)
    add_sprite(10, 8, 1);
    add_sprite(13, 8, 2);
    add_sprite(380, 4, 3);
    add_sprite(401, 3, 4);
    add_pair(12'hBAD, 1'b0, 12'hBAD, 1'b0);  // fully transparent pair (R4)
    run_line(1'b1);
    run_blank(1'b0);

    // Line 3: sprites into B (odd start at 383 wraps to 0), check A
    add_sprite(383, 2, 5);
    add_sprite(200, 16, 6);
    add_sprite(205, 16, 7);
    add_sprite(211, 5, 8);
    run_line(1'b1);
    run_blank(1'b1);

    // Line 4: check B
    run_line(1'b1);
    hblank = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule